// File: doc/BRIEF.md
# Output Pin Register with Single-Write Set and Clear

This block holds a vector of general-purpose output bits behind a small memory-mapped register bus. Software can change the pins in three ways. It can write the whole vector directly. It can write a double-width set/reset word, where the low half raises pins and the high half lowers them. It can write a bit-clear word, whose low half lowers pins. None of these ways needs a read-modify-write sequence. Each set or clear takes one bus write and never reads the output register.

The bus is a single-cycle strobe interface. A transfer is a write when `bus_sel` and `bus_we` are high at a rising clock edge. A transfer is a read when `bus_sel` is high and `bus_we` is low, and read data is returned combinationally in the same cycle. Word addresses are 0 for the data register, 1 for the set/reset register and 2 for the bit-clear register. Any other address is unmapped.

Top module: `gpio_atomic_out`

## Requirements
- R1: After reset (`rst_n` low), `pin_out` is all zeros.
- R2: A write to address 0 loads `bus_wdata[PINS-1:0]` into the pins. The new value is visible on `pin_out` after the clock edge that accepts the write.
- R3: A write to address 1 with bit i (i below PINS) set to 1 drives pin i to 1 after the accepting edge.
- R4: A write to address 1 with bit PINS+i set to 1, and bit i at 0, drives pin i to 0 after the accepting edge.
- R5: When one write to address 1 has both bit i and bit PINS+i at 1, pin i ends at 1: set wins over clear.
- R6: Any pin whose set and clear bits are both 0 in a write to address 1 or 2 keeps its previous value.
- R7: A write to address 2 with bit i (i below PINS) at 1 drives pin i to 0. Bits PINS and above of that write change no pin.
- R8: A read of address 0 returns the current pin value, zero-extended. A read of address 1 or 2, or of any unmapped address, returns all zeros.
- R9: Writes to unmapped addresses, and cycles with `bus_sel` low, leave `pin_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Transfer strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 2*PINS | Write data |
| bus_rdata | output | 2*PINS | Read data, combinational |
| pin_out | output | PINS | Registered output pin vector |

## Verification
The bench builds the block with its defaults: 16 pins and a 4-bit address. With these values, the address space holds 13 unmapped words next to the three mapped ones, so decode holes can be exercised. The set/reset word is 32 bits wide, so set and clear masks can overlap on every pin at once. The walking and overlapping patterns reach both the lowest and the highest pin, and the boundary bit between the two halves of each register.

// File: rtl/gpio_reg_pkg.sv
package gpio_reg_pkg;
  typedef enum logic [1:0] {
    K_NONE   = 2'd0,
    K_DATA   = 2'd1,
    K_SETRST = 2'd2,
    K_BITCLR = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_reg_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int OFS_DATA   = 0,
  parameter int OFS_SETRST = 1,
  parameter int OFS_BITCLR = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind
);
  always_comb begin
    if (addr == ADDR_W'(OFS_DATA))        kind = K_DATA;
    else if (addr == ADDR_W'(OFS_SETRST)) kind = K_SETRST;
    else if (addr == ADDR_W'(OFS_BITCLR)) kind = K_BITCLR;
    else                                  kind = K_NONE;
  end
endmodule

// File: rtl/gpio_out_update.sv
module gpio_out_update
  import gpio_reg_pkg::*;
#(
  parameter int PINS = 16,
  localparam int REG_W = 2 * PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_kind_e         kind,
  input  logic [REG_W-1:0]  wdata,
  output logic [PINS-1:0]   pins
);
  // Set has priority: clear only where the matching set bit is 0
  function automatic logic [PINS-1:0] apply_setrst(logic [PINS-1:0] cur,
                                                   logic [REG_W-1:0] w);
    logic [PINS-1:0] s, c;
    s = w[PINS-1:0];
    c = w[REG_W-1:PINS];
    return (cur & ~c) | s;
  endfunction

  function automatic logic [PINS-1:0] apply_bitclr(logic [PINS-1:0] cur,
                                                   logic [REG_W-1:0] w);
    return cur & ~w[PINS-1:0];
  endfunction

  logic [PINS-1:0] set_mask, clr_mask, nxt;
  logic            wr_sr, wr_bc, wr_dat;

  assign set_mask = wdata[PINS-1:0];
  assign clr_mask = wdata[REG_W-1:PINS];
  assign wr_sr    = wr_en && (kind == K_SETRST);
  assign wr_bc    = wr_en && (kind == K_BITCLR);
  assign wr_dat   = wr_en && (kind == K_DATA);

  always_comb begin
    nxt = pins;
    if (wr_dat)     nxt = wdata[PINS-1:0];
    else if (wr_sr) nxt = apply_setrst(pins, wdata);
    else if (wr_bc) nxt = apply_bitclr(pins, wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins <= '0;
    else        pins <= nxt;
  end

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sr |=> ((pins & $past(set_mask)) == $past(set_mask)));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sr |=> ((pins & $past(clr_mask) & ~$past(set_mask)) == '0));
  p_untouched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sr |=> (((pins ^ $past(pins)) & ~$past(set_mask | clr_mask)) == '0));
  p_bitclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bc |=> (((pins & $past(set_mask)) == '0) &&
               (((pins ^ $past(pins)) & ~$past(set_mask)) == '0)));
  p_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat |=> (pins == $past(set_mask)));
endmodule

// File: rtl/gpio_atomic_out.sv
module gpio_atomic_out
  import gpio_reg_pkg::*;
#(
  parameter int PINS       = 16,
  parameter int ADDR_W     = 4,
  parameter int OFS_DATA   = 0,
  parameter int OFS_SETRST = 1,
  parameter int OFS_BITCLR = 2,
  localparam int REG_W     = 2 * PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [PINS-1:0]   pin_out
);
  reg_kind_e kind;
  logic      wr_acc, rd_acc;

  assign wr_acc = bus_sel && bus_we;
  assign rd_acc = bus_sel && !bus_we;

  gpio_addr_decode #(
    .ADDR_W(ADDR_W), .OFS_DATA(OFS_DATA),
    .OFS_SETRST(OFS_SETRST), .OFS_BITCLR(OFS_BITCLR)
  ) u_dec (
    .addr(bus_addr),
    .kind(kind)
  );

  gpio_out_update #(.PINS(PINS)) u_upd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_acc), .kind(kind),
    .wdata(bus_wdata), .pins(pin_out)
  );

  // Write-only registers and holes read as zero
  always_comb begin
    bus_rdata = '0;
    if (rd_acc && kind == K_DATA) bus_rdata = REG_W'(pin_out);
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_acc || kind == K_NONE) |=> $stable(pin_out));
  p_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && bus_addr == ADDR_W'(OFS_DATA)) |-> (bus_rdata == REG_W'(pin_out)));
  p_readzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != ADDR_W'(OFS_DATA)) |-> (bus_rdata == '0));
endmodule

// File: tb/gpio_atomic_out_bench.sv
module gpio_atomic_out_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PINS = 16;
  localparam int AW   = 4;
  localparam int W    = 2 * PINS;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          sel = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic [PINS-1:0] pins;

  int n_checks = 0;
  int n_fail   = 0;
  logic [PINS-1:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_atomic_out u_gpio_atomic_out (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .pin_out(pins)
  );

  // Behavioural reference: per-pin rules straight from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model <= '0;
    else if (sel && we) begin
      logic [PINS-1:0] t;
      t = model;
      for (int i = 0; i < PINS; i++) begin
        if (addr == 0) t[i] = wdata[i];
        else if (addr == 1) begin
          if (wdata[i]) t[i] = 1'b1;
          else if (wdata[PINS+i]) t[i] = 1'b0;
        end else if (addr == 2) begin
          if (wdata[i]) t[i] = 1'b0;
        end
      end
      model <= t;
    end
  end

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Compare every cycle away from the edge
  always @(negedge clk) if (rst_n) begin
    check("R2/R3/R4/R5/R6/R7/R9 pins vs model", W'(pins), W'(model));
    check("R8 readback vs model",
          (sel && !we && addr == 0) ? W'(model) : '0, rdata);
  end

  task automatic wr(logic [AW-1:0] a, logic [W-1:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0; wdata = '0;
  endtask

  task automatic rd_check(string req, logic [AW-1:0] a, logic [W-1:0] exp);
    @(negedge clk); sel = 1; we = 0; addr = a;
    #1 check(req, rdata, exp);
    @(negedge clk); sel = 0;
  endtask

  initial begin
    #(CLK_PERIOD*1000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pins", W'(pins), '0);
    rst_n = 1;
    @(negedge clk);
    check("R1 pins after release", W'(pins), '0);
    wr(0, 32'hFFFF_A5C3);
    check("R2 direct write", W'(pins), 32'h0000_A5C3);
    rd_check("R8 read data reg", 0, 32'h0000_A5C3);
    rd_check("R8 read setrst zero", 1, '0);
    rd_check("R8 read bitclr zero", 2, '0);
    rd_check("R8 read hole zero", 4'hF, '0);
    wr(1, 32'h0000_8001);
    check("R3 set bits 0,15", W'(pins), 32'h0000_A5C3 | 32'h8001);
    wr(1, 32'h8001_0000);
    check("R4 clear bits 0,15", W'(pins), 32'h0000_25C2);
    wr(1, 32'h0004_0004);
    check("R5 set wins bit2", W'(pins), 32'h0000_25C6);
    wr(1, 32'h0000_0000);
    check("R6 zero setrst no change", W'(pins), 32'h0000_25C6);
    wr(2, 32'hFFFF_0000);
    check("R7 upper bitclr ignored", W'(pins), 32'h0000_25C6);
    wr(2, 32'h0000_0006);
    check("R7 bitclr low", W'(pins), 32'h0000_25C0);
    wr(4'h3, 32'h0000_FFFF);
    check("R9 hole write ignored", W'(pins), 32'h0000_25C0);
    @(negedge clk); sel = 0; we = 1; addr = 0; wdata = 32'hFFFF;
    @(negedge clk); we = 0;
    check("R9 no sel no write", W'(pins), 32'h0000_25C0);
    wr(1, 32'hFFFF_FFFF);
    check("R5 all overlap set wins", W'(pins), 32'h0000_FFFF);
    for (int i = 0; i < PINS; i++) wr(2, W'(1) << i);
    check("R7 walking clear", W'(pins), '0);
    for (int i = 0; i < PINS; i++) wr(1, W'(1) << i);
    check("R3 walking set", W'(pins), 32'h0000_FFFF);
    rd_check("R8 read after walk", 0, 32'h0000_FFFF);
    rst_n = 0; #1;
    check("R1 async reset", W'(pins), '0);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule